// File: doc/BRIEF.md
# Receive Byte FIFO with Fill-Level Status

This block buffers the bytes that a serial receive engine produces, one byte per accepted push, and hands them to software as 32-bit words through a single read port. Each read returns up to four bytes in arrival order and removes exactly the bytes it returned. If fewer than four bytes are held, the word carries those bytes in its low lanes and zeros above them. When the buffer holds its full 64 bytes, it deasserts its push-ready output, so the receive engine waits and no byte is dropped.

A 32-bit status word reports the fill level and several flags: empty, a general ready flag, and three threshold flags that show whether at least 16, 32 or 64 bytes are waiting. The ready flag is raised once a whole word is available. It is also raised when the transfer has ended and a partial word is left. A one-cycle flush request empties the buffer. A read of an empty buffer sets a sticky underrun interrupt bit, which stays set until software clears it. A second interrupt bit follows the ready flag.

Top module: `rx_byte_fifo`

## Requirements
- R1: A push with `push_valid_i` high while `push_ready_o` is high stores `push_byte_i`, and the byte count in status bits 10:4 rises by one on the next cycle.
- R2: With 64 bytes held, `push_ready_o` is low. A push offered then is not stored, and the byte stays with the sender until space frees up.
- R3: `pop_data_o` places the oldest held byte in bits 7:0, the next in 15:8, then 23:16 and 31:24.
- R4: A read pulse on `pop_req_i` removes min(4, count) bytes. Lanes above the bytes held read as zero, so an empty buffer returns 0.
- R5: Status bit 11 is 1 exactly when no byte is held.
- R6: Status bits 1, 2 and 3 are 1 when the count is at least 16, 32 and 64 respectively.
- R7: Status bit 0 (ready) is 1 when the count is at least 4, or when `xfer_done_i` is high and the count is nonzero.
- R8: A `flush_i` pulse empties the buffer on the next cycle. A push or a read in that same cycle changes nothing beyond the flush.
- R9: A read pulse while empty sets `irq_status_o[0]`. The bit stays set until an `irq_clr_i` pulse. A new underrun in the same cycle as a clear wins.
- R10: `irq_status_o[2]` equals the ready flag and `irq_status_o[1]` is 0.
- R11: After reset the count is 0, the buffer is empty, both interrupt bits are 0 and `push_ready_o` is 1.
- R12: A push and a read in the same cycle leave count − min(4, count) + 1 bytes, with the new byte placed behind the remaining ones.
- All other status bits (31:12) read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| push_valid_i | input | 1 | Receive engine offers a byte |
| push_byte_i | input | 8 | Offered byte |
| push_ready_o | output | 1 | Space available; push accepted when high |
| xfer_done_i | input | 1 | Current transfer has ended (level) |
| pop_req_i | input | 1 | Software read of the data word (one pulse per read) |
| pop_data_o | output | 32 | Word returned for the read in this cycle |
| flush_i | input | 1 | Self-clearing flush request |
| irq_clr_i | input | 1 | Clears the sticky underrun bit |
| fifo_status_o | output | 32 | Ready, threshold, count and empty fields |
| irq_status_o | output | 3 | Bit 0 underrun (sticky), bit 2 ready |

## Verification
A push, read, flush or clear sampled at a rising edge becomes visible in the count, flags, data word and interrupt bits right after that edge, one cycle of latency. The ready flag and interrupt bit 2 also depend on `xfer_done_i` in the same cycle, with no register in between. `pop_data_o` is a combinational view of the current head, so it is valid in the same cycle as the read pulse that consumes it. The bench drives every input on the falling edge and advances its queue model on the rising edge. Just before each new set of inputs, it compares every output with the model's prediction for the inputs currently applied, so each result is checked in the first cycle it is due.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    // status word field positions (software decodes these)
    localparam int unsigned ST_READY     = 0;
    localparam int unsigned ST_THR_LSB   = 1;
    localparam int unsigned ST_CNT_LSB   = 4;
    localparam int unsigned ST_CNT_W     = 7;
    localparam int unsigned ST_EMPTY     = 11;
    // interrupt bit positions
    localparam int unsigned IRQ_UNDERRUN = 0;
    localparam int unsigned IRQ_READY    = 2;
    localparam int unsigned IRQ_W        = 3;
    // bytes per software word
    localparam int unsigned LANES        = 4;
endpackage

// File: rtl/rxf_ptr_ctrl.sv
module rxf_ptr_ctrl #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned PTR_W = $clog2(DEPTH),
    parameter int unsigned CNT_W = $clog2(DEPTH) + 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             push_valid_i,
    input  logic             pop_req_i,
    input  logic             flush_i,
    output logic             push_en_o,
    output logic             push_ready_o,
    output logic [PTR_W-1:0] wr_ptr_o,
    output logic [PTR_W-1:0] rd_ptr_o,
    output logic [CNT_W-1:0] count_o
);
    import rxf_pkg::*;

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    logic             full;
    logic [CNT_W-1:0] pop_n;

    always_comb begin
        st_d      = st_q;
        full      = (st_q.cnt == CNT_W'(DEPTH));
        pop_n     = '0;
        if (pop_req_i) begin
            pop_n = (st_q.cnt >= CNT_W'(LANES)) ? CNT_W'(LANES) : st_q.cnt;
        end
        push_en_o = push_valid_i && !full && !flush_i;
        if (flush_i) begin
            st_d = '0;
        end else begin
            st_d.rd  = st_q.rd + PTR_W'(pop_n);
            st_d.wr  = st_q.wr + PTR_W'(push_en_o);
            st_d.cnt = st_q.cnt - pop_n + CNT_W'(push_en_o);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign push_ready_o = !full;
    assign wr_ptr_o     = st_q.wr;
    assign rd_ptr_o     = st_q.rd;
    assign count_o      = st_q.cnt;
endmodule

// File: rtl/rxf_byte_ram.sv
module rxf_byte_ram #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned PTR_W = $clog2(DEPTH),
    parameter int unsigned CNT_W = $clog2(DEPTH) + 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             we_i,
    input  logic [PTR_W-1:0] wr_ptr_i,
    input  logic [7:0]       wr_byte_i,
    input  logic [PTR_W-1:0] rd_ptr_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [31:0]      rd_word_o
);
    import rxf_pkg::*;

    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we_i) mem_d[wr_ptr_i] = wr_byte_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
        end else begin
            mem_q <= mem_d;
        end
    end

    // one lane per byte of the returned word; lanes beyond the fill read zero
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [PTR_W-1:0] idx;
        assign idx = rd_ptr_i + PTR_W'(k);
        assign rd_word_o[8*k +: 8] = (count_i > CNT_W'(k)) ? mem_q[idx] : 8'h00;
    end
endmodule

// File: rtl/rxf_status.sv
module rxf_status #(
    parameter int unsigned DEPTH    = 64,
    parameter int unsigned CNT_W    = $clog2(DEPTH) + 1,
    parameter int unsigned THR_BASE = 16,
    parameter int unsigned NUM_THR  = 3
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [CNT_W-1:0]          count_i,
    input  logic                      xfer_done_i,
    input  logic                      pop_req_i,
    input  logic                      irq_clr_i,
    output logic [31:0]               status_o,
    output logic [rxf_pkg::IRQ_W-1:0] irq_o
);
    import rxf_pkg::*;

    typedef struct packed {
        logic underrun;
    } irq_state_t;

    irq_state_t st_d, st_q;
    logic               ready;
    logic               empty;
    logic [NUM_THR-1:0] thr_hit;

    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
        assign thr_hit[t] = (count_i >= CNT_W'(THR_BASE << t));
    end

    always_comb begin
        empty = (count_i == '0);
        ready = (count_i >= CNT_W'(LANES)) || (xfer_done_i && !empty);
        st_d  = st_q;
        if (pop_req_i && empty)  st_d.underrun = 1'b1;
        else if (irq_clr_i)      st_d.underrun = 1'b0;

        status_o                           = '0;
        status_o[ST_READY]                 = ready;
        status_o[ST_THR_LSB +: NUM_THR]    = thr_hit;
        status_o[ST_CNT_LSB +: ST_CNT_W]   = ST_CNT_W'(count_i);
        status_o[ST_EMPTY]                 = empty;

        irq_o               = '0;
        irq_o[IRQ_UNDERRUN] = st_q.underrun;
        irq_o[IRQ_READY]    = ready;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/rx_byte_fifo.sv
module rx_byte_fifo #(
    parameter int unsigned DEPTH = 64
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        push_valid_i,
    input  logic [7:0]  push_byte_i,
    output logic        push_ready_o,
    input  logic        xfer_done_i,
    input  logic        pop_req_i,
    output logic [31:0] pop_data_o,
    input  logic        flush_i,
    input  logic        irq_clr_i,
    output logic [31:0] fifo_status_o,
    output logic [2:0]  irq_status_o
);
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = PTR_W + 1;

    logic             push_en;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;

    rxf_ptr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ptr (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .push_valid_i (push_valid_i),
        .pop_req_i    (pop_req_i),
        .flush_i      (flush_i),
        .push_en_o    (push_en),
        .push_ready_o (push_ready_o),
        .wr_ptr_o     (wr_ptr),
        .rd_ptr_o     (rd_ptr),
        .count_o      (count)
    );

    rxf_byte_ram #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ram (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .we_i      (push_en),
        .wr_ptr_i  (wr_ptr),
        .wr_byte_i (push_byte_i),
        .rd_ptr_i  (rd_ptr),
        .count_i   (count),
        .rd_word_o (pop_data_o)
    );

    rxf_status #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_stat (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .count_i     (count),
        .xfer_done_i (xfer_done_i),
        .pop_req_i   (pop_req_i),
        .irq_clr_i   (irq_clr_i),
        .status_o    (fifo_status_o),
        .irq_o       (irq_status_o)
    );
endmodule

// File: rtl/rx_byte_fifo_chk.sv
module rx_byte_fifo_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        push_valid_i,
    input logic [7:0]  push_byte_i,
    input logic        push_ready_o,
    input logic        xfer_done_i,
    input logic        pop_req_i,
    input logic [31:0] pop_data_o,
    input logic        flush_i,
    input logic        irq_clr_i,
    input logic [31:0] fifo_status_o,
    input logic [2:0]  irq_status_o
);
    logic [6:0] cnt;
    assign cnt = fifo_status_o[10:4];

    AST_PUSH_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_valid_i && push_ready_o && !pop_req_i && !flush_i) |=> (cnt == $past(cnt) + 7'd1)); // R1
    AST_FULL_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt == 7'd64) |-> !push_ready_o); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt <= 7'd64); // R2
    AST_EMPTY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fifo_status_o[11] |-> (pop_data_o == 32'h0)); // R4
    AST_THR_NEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fifo_status_o[3] |-> (fifo_status_o[2] && fifo_status_o[1])); // R6
    AST_READY_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fifo_status_o[0] |-> !fifo_status_o[11]); // R7
    AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> fifo_status_o[11]); // R8
    AST_UNDERRUN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pop_req_i && fifo_status_o[11]) |=> irq_status_o[0]); // R9
endmodule

bind rx_byte_fifo rx_byte_fifo_chk u_chk (.*);

// File: tb/rx_byte_fifo_bench.sv
`timescale 1ns/1ps
module rx_byte_fifo_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid = 1'b0;
    logic [7:0]  push_byte = 8'h00;
    logic        push_ready;
    logic        xfer_done = 1'b0;
    logic        pop_req = 1'b0;
    logic [31:0] pop_data;
    logic        flush = 1'b0;
    logic        irq_clr = 1'b0;
    logic [31:0] fstat;
    logic [2:0]  irq;

    int vectors = 0;
    int errors  = 0;
    bit done_run = 0;

    always #4 clk = ~clk;

    rx_byte_fifo u_rx_byte_fifo (
        .clk_i(clk), .rst_ni(rst_n), .push_valid_i(push_valid), .push_byte_i(push_byte),
        .push_ready_o(push_ready), .xfer_done_i(xfer_done), .pop_req_i(pop_req),
        .pop_data_o(pop_data), .flush_i(flush), .irq_clr_i(irq_clr),
        .fifo_status_o(fstat), .irq_status_o(irq)
    );

    // behavioural reference: a byte queue plus a sticky flag
    byte unsigned mq[$];
    bit m_und = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_und = 0;
        end else begin
            int sz;
            bit und_evt;
            sz = mq.size();
            und_evt = pop_req && (sz == 0);
            if (flush) mq.delete();
            else begin
                if (pop_req) begin
                    int n;
                    n = (sz < 4) ? sz : 4;
                    for (int i = 0; i < n; i++) void'(mq.pop_front());
                end
                if (push_valid && sz < 64) mq.push_back(push_byte);
            end
            if (und_evt) m_und = 1;
            else if (irq_clr) m_und = 0;
        end
    end

    task automatic cmp(string tag, string field, logic [31:0] got, logic [31:0] exp);
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h exp %0h", tag, field, got, exp);
        end
    endtask

    task automatic check(string tag);
        int sz;
        logic [31:0] w;
        bit rdy;
        sz = mq.size();
        w = 32'h0;
        for (int i = 0; i < 4 && i < sz; i++) w[8*i +: 8] = mq[i];
        rdy = (sz >= 4) || (xfer_done && sz > 0);
        vectors++;
        cmp(tag, "R1 count",      {25'h0, fstat[10:4]}, sz);
        cmp(tag, "R5 empty",      {31'h0, fstat[11]}, {31'h0, sz == 0});
        cmp(tag, "R6 thresholds", {29'h0, fstat[3:1]}, {29'h0, sz >= 64, sz >= 32, sz >= 16});
        cmp(tag, "R7 ready",      {31'h0, fstat[0]}, {31'h0, rdy});
        cmp(tag, "upper status",  {20'h0, fstat[31:12]}, 32'h0);
        cmp(tag, "R3 data",       pop_data, w);
        cmp(tag, "R2 push_ready", {31'h0, push_ready}, {31'h0, sz < 64});
        cmp(tag, "R9 underrun",   {31'h0, irq[0]}, {31'h0, m_und});
        cmp(tag, "R10 irq ready", {30'h0, irq[2:1]}, {30'h0, rdy, 1'b0});
    endtask

    // compare at the falling edge, then apply the next inputs
    task automatic step(string tag, bit pv, logic [7:0] pb, bit pr, bit fl, bit cl, bit dn);
        @(negedge clk);
        check(tag);
        push_valid = pv; push_byte = pb; pop_req = pr;
        flush = fl; irq_clr = cl; xfer_done = dn;
    endtask

    task automatic idle(string tag, bit dn);
        step(tag, 0, 8'h00, 0, 0, 0, dn);
    endtask

    initial begin
        int unsigned seed;
        seed = 32'h1234_5678;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle("R11 reset state", 0);
        idle("R11 reset state", 0);
        // R1 R3 R4: seven bytes, then read 4 and 3
        for (int i = 0; i < 7; i++) step("R1 push", 1, 8'hA0 + 8'(i), 0, 0, 0, 0);
        idle("R1 R3 seven held", 0);
        idle("R7 partial done", 1);
        step("R3 read full word", 0, 8'h00, 1, 0, 0, 1);
        step("R4 read tail", 0, 8'h00, 1, 0, 0, 1);
        idle("R4 R5 empty after tail", 0);
        // R7: two bytes, ready only with done
        step("R7 push", 1, 8'h11, 0, 0, 0, 0);
        step("R7 push", 1, 8'h22, 0, 0, 0, 0);
        idle("R7 two bytes no done", 0);
        idle("R7 two bytes done", 1);
        step("R4 short read", 0, 8'h00, 1, 0, 0, 0);
        // R2 R6: fill past 64 with a held push
        for (int i = 0; i < 70; i++) step("R2 R6 fill", 1, 8'(i), 0, 0, 0, 0);
        idle("R2 full stall", 0);
        // R12 at full: push refused, read pops 4
        step("R12 pop at full", 1, 8'hEE, 1, 0, 0, 0);
        step("R12 push and pop", 1, 8'hEF, 1, 0, 0, 0);
        idle("R12 settle", 0);
        // R8 flush with push and read
        step("R8 flush", 1, 8'h55, 1, 1, 0, 0);
        idle("R8 after flush", 0);
        // R9 underrun, clear, collision
        step("R9 read empty", 0, 8'h00, 1, 0, 0, 0);
        idle("R9 sticky", 0);
        idle("R9 sticky", 0);
        step("R9 clear", 0, 8'h00, 0, 0, 1, 0);
        idle("R9 cleared", 0);
        step("R9 set wins over clear", 0, 8'h00, 1, 0, 1, 0);
        idle("R9 still set", 0);
        step("R9 clear", 0, 8'h00, 0, 0, 1, 0);
        // R12 random mix
        for (int i = 0; i < 4000; i++) begin
            bit pv, pr, fl, cl, dn;
            seed = seed * 1103515245 + 12345;
            pv = seed[20:18] != 0;
            pr = seed[23:21] == 0;
            fl = seed[31:26] == 0;
            cl = seed[25:24] == 0;
            dn = seed[17];
            step("R12 random", pv, seed[15:8], pr, fl, cl, dn);
        end
        idle("final", 0);
        idle("final", 0);
        done_run = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_run) begin
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule